// File: doc/BRIEF.md
# Serial Bit-Clock Enable Generator

This block produces the bit-rate timing for one serial channel. The channel runs either as an asynchronous UART or as a clock-synchronous serial port. The peripheral clock is first cut down by a two-stage prescaler, and the block picks one of its outputs. A reload counter then divides that output by `n+1`. A final stage turns the result into transmit and receive tick pulses: one tick every sixteen divider pulses in UART modes, or a half-rate serial clock that is driven on the clock pin in synchronous mode. Every timing signal is a single-cycle enable on the system clock. No derived clocks are created.

In synchronous mode the serial clock can also come from the clock pin. That pin is synchronised and edge-detected, and the clock-polarity option inverts it in both directions. The shared handshake pin can be left unused, used as a low-active clear-to-send input, or used as a request-to-send output that follows the receiver-ready flag. Two further options invert the receive data input and the transmit data output. Shift registers and framing sit outside this block and consume `tx_tick`, `rx_tick` and `cts_ok`.

Top module: `baud_tick_gen`

## Requirements
- R1: With `cfg_pclk_full`=1 the base count source is one pulse per system clock. With `cfg_pclk_full`=0 it is one pulse every two system clocks.
- R2: `cfg_src_sel` picks the count source: 00 is the base source, 01 is the base divided by 8, and 10 is the base divided by 32. Value 11 stops all internally timed ticks.
- R3: The reload divider emits one pulse per `n+1` count-source pulses, where `n` is the value written through `cfg_reload`.
- R4: For `cfg_mode` codes 010, 100, 101 and 110, `tx_tick` and `rx_tick` pulse together for one cycle once every 16 divider pulses.
- R5: In mode 001 with `cfg_ext_clk`=0, `sclk_oe`=1 and the internal clock level toggles on every divider pulse. `tx_tick` fires in the cycle before the level falls, and `rx_tick` fires in the cycle before it rises. Each tick therefore repeats every 2 divider pulses.
- R6: In mode 001 with `cfg_ext_clk`=1, `sclk_oe`=0. A rising edge of the pin level gives `rx_tick`, and a falling edge gives `tx_tick`, visible in the cycle after the second system clock edge that follows the pin change. In UART modes `cfg_ext_clk` is ignored and internal timing is used.
- R7: `cfg_clk_inv`=1 inverts the level on `sclk_out` and the level taken from `sclk_in`.
- R8: Mode codes 000, 011 and 111 give no ticks and `sclk_oe`=0.
- R9: Asserting `cfg_reload_wr` restarts the whole divider chain. In UART mode with a full-rate source and `cfg_src_sel`=00, the first tick appears 16·(n+1) clock edges after the write edge.
- R10: With `cfg_hs_off`=1, `cts_ok`=1 and `rts_oe`=0. With `cfg_hs_off`=0 and `cfg_hs_rts`=0, `cts_ok` is the inverse of `cts_n_in` after two clock edges. With `cfg_hs_off`=0 and `cfg_hs_rts`=1, `rts_oe`=1, `rts_n_out` is the inverse of `rx_ready`, and `cts_ok`=1.
- R11: `rxd_int` equals `rxd_pin` XOR `cfg_rx_inv`, and `txd_pin` equals `txd_int` XOR `cfg_tx_inv`.
- R12: After reset, `tx_tick`, `rx_tick` and `sclk_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pclk_full | input | 1 | 1: full-rate base source, 0: half rate |
| cfg_src_sel | input | 2 | Count source select |
| cfg_reload | input | RELOAD_W | Reload value n |
| cfg_reload_wr | input | 1 | Reload write strobe, restarts the chain |
| cfg_mode | input | 3 | Channel mode code |
| cfg_ext_clk | input | 1 | 1: serial clock taken from the pin (synchronous mode) |
| cfg_clk_inv | input | 1 | Clock pin polarity inversion |
| cfg_hs_off | input | 1 | Handshake pin unused |
| cfg_hs_rts | input | 1 | 1: pin is RTS output, 0: pin is CTS input |
| cfg_rx_inv | input | 1 | Invert receive data |
| cfg_tx_inv | input | 1 | Invert transmit data |
| sclk_in | input | 1 | Clock pin input level |
| cts_n_in | input | 1 | Clear-to-send pin, low active |
| rx_ready | input | 1 | Receiver can accept data |
| rxd_pin | input | 1 | Receive data pin |
| txd_int | input | 1 | Transmit data from the shifter |
| tx_tick | output | 1 | Transmit bit enable |
| rx_tick | output | 1 | Receive bit enable |
| sclk_out | output | 1 | Clock pin output level |
| sclk_oe | output | 1 | Clock pin output enable |
| rts_n_out | output | 1 | Request-to-send level, low active |
| rts_oe | output | 1 | Handshake pin output enable |
| cts_ok | output | 1 | Transmission may start |
| rxd_int | output | 1 | Receive data after optional inversion |
| txd_pin | output | 1 | Transmit data pin after optional inversion |

## Verification
The bench measures tick spacing across random mixes of base rate, source select, reload value and mode. A design with an off-by-one in the reload count, or one that uses the wrong prescaler tap, shows up as a wrong interval. Directed cases cover the reserved source select and the unused mode codes; a design that leaked stale divider pulses there would still emit ticks. A restart case times the first UART tick after a reload write; a divider that kept its old count would be early or late. External-clock, polarity, handshake and data-inversion cases count synchroniser edges exactly, so an extra or missing flop, or an edge direction that is swapped, is caught.

// File: rtl/baud_pkg.sv
package baud_pkg;

   typedef enum logic [1:0] {
      STAGE_OFF  = 2'd0,
      STAGE_UART = 2'd1,
      STAGE_SYNC = 2'd2
   } stage_e;

   function automatic stage_e decode_mode(input logic [2:0] code);
      case (code)
         3'b010, 3'b100, 3'b101, 3'b110: decode_mode = STAGE_UART;
         3'b001:                         decode_mode = STAGE_SYNC;
         default:                        decode_mode = STAGE_OFF;
      endcase
   endfunction

endpackage

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
   parameter int DIV_A = 8,
   parameter int DIV_B = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       pclk_full,
   input  logic [1:0] src_sel,
   output logic       src_en
);
   localparam int AW = (DIV_A > 1) ? $clog2(DIV_A) : 1;
   localparam int BW = (DIV_B > 1) ? $clog2(DIV_B) : 1;

   generate
      if (DIV_A < 2) begin : g_bad_a
         $error("DIV_A must be at least 2");
      end
      if (DIV_B < 2) begin : g_bad_b
         $error("DIV_B must be at least 2");
      end
   endgenerate

   logic          half_q;
   logic [AW-1:0] cnt_a;
   logic [BW-1:0] cnt_b;
   logic          base_en, a_en, b_en;

   assign base_en = pclk_full | half_q;
   assign a_en    = base_en && (cnt_a == AW'(DIV_A - 1));
   assign b_en    = a_en && (cnt_b == BW'(DIV_B - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         cnt_a  <= '0;
         cnt_b  <= '0;
      end else if (restart) begin
         half_q <= 1'b0;
         cnt_a  <= '0;
         cnt_b  <= '0;
      end else begin
         half_q <= ~half_q;
         if (base_en) cnt_a <= a_en ? '0 : cnt_a + 1'b1;
         if (a_en)    cnt_b <= b_en ? '0 : cnt_b + 1'b1;
      end
   end

   always_comb begin
      case (src_sel)
         2'b00:   src_en = base_en;
         2'b01:   src_en = a_en;
         2'b10:   src_en = b_en;
         default: src_en = 1'b0;
      endcase
   end

endmodule

// File: rtl/baud_reload_div.sv
module baud_reload_div #(
   parameter int RELOAD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart,
   input  logic [RELOAD_W-1:0] restart_val,
   input  logic [RELOAD_W-1:0] reload_val,
   input  logic                src_en,
   output logic                brg_q
);
   logic [RELOAD_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         brg_q <= 1'b0;
      end else if (restart) begin
         cnt   <= restart_val;
         brg_q <= 1'b0;
      end else begin
         brg_q <= 1'b0;
         if (src_en) begin
            if (cnt == '0) begin
               cnt   <= reload_val;
               brg_q <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/baud_sync.sv
module baud_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/baud_final_stage.sv
module baud_final_stage
   import baud_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   restart,
   input  stage_e stage,
   input  logic   brg_en,
   input  logic   ext_mode,
   input  logic   ext_rise,
   input  logic   ext_fall,
   output logic   tx_tick,
   output logic   rx_tick,
   output logic   ph
);
   localparam int OW = (OVS > 1) ? $clog2(OVS) : 1;
   localparam bit OVS_POW2 = (OVS > 1) && ((OVS & (OVS - 1)) == 0);

   generate
      if (OVS < 2) begin : g_bad_ovs
         $error("OVS must be at least 2");
      end
   endgenerate

   logic [OW-1:0] ovs_cnt;
   logic          ovs_last;
   logic          uart_on, sync_int, sync_ext;

   assign uart_on  = (stage == STAGE_UART);
   assign sync_int = (stage == STAGE_SYNC) && !ext_mode;
   assign sync_ext = (stage == STAGE_SYNC) && ext_mode;
   assign ovs_last = (ovs_cnt == OW'(OVS - 1));

   generate
      if (OVS_POW2) begin : g_ovs_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   ovs_cnt <= '0;
            else if (restart)             ovs_cnt <= '0;
            else if (uart_on && brg_en)   ovs_cnt <= ovs_cnt + 1'b1;
         end
      end else begin : g_ovs_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   ovs_cnt <= '0;
            else if (restart)             ovs_cnt <= '0;
            else if (uart_on && brg_en)   ovs_cnt <= ovs_last ? '0 : ovs_cnt + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  ph <= 1'b1;
      else if (restart)            ph <= 1'b1;
      else if (sync_int && brg_en) ph <= ~ph;
   end

   always_comb begin
      tx_tick = 1'b0;
      rx_tick = 1'b0;
      if (uart_on) begin
         tx_tick = brg_en && ovs_last;
         rx_tick = brg_en && ovs_last;
      end else if (sync_int) begin
         tx_tick = brg_en && ph;
         rx_tick = brg_en && !ph;
      end else if (sync_ext) begin
         tx_tick = ext_fall;
         rx_tick = ext_rise;
      end
   end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
   import baud_pkg::*;
#(
   parameter int RELOAD_W    = 8,
   parameter int PRE_DIV_A   = 8,
   parameter int PRE_DIV_B   = 4,
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_pclk_full,
   input  logic [1:0]          cfg_src_sel,
   input  logic [RELOAD_W-1:0] cfg_reload,
   input  logic                cfg_reload_wr,
   input  logic [2:0]          cfg_mode,
   input  logic                cfg_ext_clk,
   input  logic                cfg_clk_inv,
   input  logic                cfg_hs_off,
   input  logic                cfg_hs_rts,
   input  logic                cfg_rx_inv,
   input  logic                cfg_tx_inv,
   input  logic                sclk_in,
   input  logic                cts_n_in,
   input  logic                rx_ready,
   input  logic                rxd_pin,
   input  logic                txd_int,
   output logic                tx_tick,
   output logic                rx_tick,
   output logic                sclk_out,
   output logic                sclk_oe,
   output logic                rts_n_out,
   output logic                rts_oe,
   output logic                cts_ok,
   output logic                rxd_int,
   output logic                txd_pin
);
   generate
      if (RELOAD_W < 2 || RELOAD_W > 16) begin : g_bad_w
         $error("RELOAD_W out of range 2..16");
      end
   endgenerate

   stage_e              stage;
   logic [RELOAD_W-1:0] reload_q;
   logic                src_en, brg_en, ph;
   logic                sclk_lvl, sclk_s, sclk_prev;
   logic                ext_rise, ext_fall;
   logic                cts_s;

   assign stage = decode_mode(cfg_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             reload_q <= '0;
      else if (cfg_reload_wr) reload_q <= cfg_reload;
   end

   baud_prescaler #(.DIV_A(PRE_DIV_A), .DIV_B(PRE_DIV_B)) i_pre (
      .clk(clk), .rst_n(rst_n), .restart(cfg_reload_wr),
      .pclk_full(cfg_pclk_full), .src_sel(cfg_src_sel), .src_en(src_en)
   );

   baud_reload_div #(.RELOAD_W(RELOAD_W)) i_div (
      .clk(clk), .rst_n(rst_n), .restart(cfg_reload_wr),
      .restart_val(cfg_reload), .reload_val(reload_q),
      .src_en(src_en), .brg_q(brg_en)
   );

   assign sclk_lvl = sclk_in ^ cfg_clk_inv;

   baud_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sclk_sync (
      .clk(clk), .rst_n(rst_n), .d(sclk_lvl), .q(sclk_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign ext_rise = sclk_s & ~sclk_prev;
   assign ext_fall = ~sclk_s & sclk_prev;

   baud_final_stage #(.OVS(OVERSAMPLE)) i_fin (
      .clk(clk), .rst_n(rst_n), .restart(cfg_reload_wr), .stage(stage),
      .brg_en(brg_en), .ext_mode(cfg_ext_clk), .ext_rise(ext_rise),
      .ext_fall(ext_fall), .tx_tick(tx_tick), .rx_tick(rx_tick), .ph(ph)
   );

   assign sclk_out = ph ^ cfg_clk_inv;
   assign sclk_oe  = (stage == STAGE_SYNC) && !cfg_ext_clk;

   baud_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_cts_sync (
      .clk(clk), .rst_n(rst_n), .d(cts_n_in), .q(cts_s)
   );

   assign rts_oe    = !cfg_hs_off && cfg_hs_rts;
   assign rts_n_out = rts_oe ? !rx_ready : 1'b1;
   assign cts_ok    = cfg_hs_off || cfg_hs_rts || !cts_s;

   assign rxd_int = rxd_pin ^ cfg_rx_inv;
   assign txd_pin = txd_int ^ cfg_tx_inv;

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_src_sel,
   input logic       cfg_reload_wr,
   input logic [2:0] cfg_mode,
   input logic       cfg_ext_clk,
   input logic       cfg_clk_inv,
   input logic       cfg_hs_off,
   input logic       cfg_hs_rts,
   input logic       rx_ready,
   input logic       tx_tick,
   input logic       rx_tick,
   input logic       sclk_out,
   input logic       sclk_oe,
   input logic       rts_n_out,
   input logic       rts_oe,
   input logic       cts_ok
);
   logic is_uart, is_sync, is_sync_int;

   assign is_uart     = (cfg_mode == 3'b010) || (cfg_mode == 3'b100) ||
                        (cfg_mode == 3'b101) || (cfg_mode == 3'b110);
   assign is_sync     = (cfg_mode == 3'b001);
   assign is_sync_int = is_sync && !cfg_ext_clk;

   // R4
   uart_coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_uart |-> (tx_tick == rx_tick));

   // R4
   uart_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_uart && tx_tick && !cfg_reload_wr) |=> (!is_uart || !tx_tick));

   // R5
   sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sync_int && tx_tick && !cfg_reload_wr) |=> !(sclk_out ^ cfg_clk_inv));

   // R6
   ext_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ext_clk |-> !sclk_oe);

   // R8
   off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_uart && !is_sync) |-> (!tx_tick && !rx_tick && !sclk_oe));

   // R2
   sel_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_src_sel == 2'b11 && $past(cfg_src_sel == 2'b11) && !(is_sync && cfg_ext_clk))
      |-> (!tx_tick && !rx_tick));

   // R10
   rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_hs_off && cfg_hs_rts) |-> (rts_oe && rts_n_out == !rx_ready && cts_ok));

   // R10
   hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_hs_off |-> (cts_ok && !rts_oe));

endmodule

bind baud_tick_gen baud_tick_gen_chk i_chk (
   .clk(clk), .rst_n(rst_n), .cfg_src_sel(cfg_src_sel),
   .cfg_reload_wr(cfg_reload_wr), .cfg_mode(cfg_mode),
   .cfg_ext_clk(cfg_ext_clk), .cfg_clk_inv(cfg_clk_inv),
   .cfg_hs_off(cfg_hs_off), .cfg_hs_rts(cfg_hs_rts), .rx_ready(rx_ready),
   .tx_tick(tx_tick), .rx_tick(rx_tick), .sclk_out(sclk_out),
   .sclk_oe(sclk_oe), .rts_n_out(rts_n_out), .rts_oe(rts_oe), .cts_ok(cts_ok)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;
   localparam int RW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_pclk_full = 1'b1;
   logic [1:0]    cfg_src_sel = 2'b00;
   logic [RW-1:0] cfg_reload = '0;
   logic          cfg_reload_wr = 1'b0;
   logic [2:0]    cfg_mode = 3'b000;
   logic          cfg_ext_clk = 1'b0;
   logic          cfg_clk_inv = 1'b0;
   logic          cfg_hs_off = 1'b1;
   logic          cfg_hs_rts = 1'b0;
   logic          cfg_rx_inv = 1'b0;
   logic          cfg_tx_inv = 1'b0;
   logic          sclk_in = 1'b0;
   logic          cts_n_in = 1'b1;
   logic          rx_ready = 1'b0;
   logic          rxd_pin = 1'b0;
   logic          txd_int = 1'b0;
   logic          tx_tick, rx_tick, sclk_out, sclk_oe;
   logic          rts_n_out, rts_oe, cts_ok, rxd_int, txd_pin;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   baud_tick_gen #(.RELOAD_W(RW)) i_baud_tick_gen (
      .clk(clk), .rst_n(rst_n), .cfg_pclk_full(cfg_pclk_full),
      .cfg_src_sel(cfg_src_sel), .cfg_reload(cfg_reload),
      .cfg_reload_wr(cfg_reload_wr), .cfg_mode(cfg_mode),
      .cfg_ext_clk(cfg_ext_clk), .cfg_clk_inv(cfg_clk_inv),
      .cfg_hs_off(cfg_hs_off), .cfg_hs_rts(cfg_hs_rts),
      .cfg_rx_inv(cfg_rx_inv), .cfg_tx_inv(cfg_tx_inv), .sclk_in(sclk_in),
      .cts_n_in(cts_n_in), .rx_ready(rx_ready), .rxd_pin(rxd_pin),
      .txd_int(txd_int), .tx_tick(tx_tick), .rx_tick(rx_tick),
      .sclk_out(sclk_out), .sclk_oe(sclk_oe), .rts_n_out(rts_n_out),
      .rts_oe(rts_oe), .cts_ok(cts_ok), .rxd_int(rxd_int), .txd_pin(txd_pin)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_period(input bit full, input int sel, input int n, input bit uart);
      int ps;
      ps = (sel == 0) ? 1 : ((sel == 1) ? 8 : 32);
      return (full ? 1 : 2) * ps * (n + 1) * (uart ? 16 : 2);
   endfunction

   task automatic configure(input bit full, input int sel, input int n,
                            input logic [2:0] mode, input bit ext, input bit inv);
      @(negedge clk);
      cfg_pclk_full = full;
      cfg_src_sel   = sel[1:0];
      cfg_reload    = n[RW-1:0];
      cfg_mode      = mode;
      cfg_ext_clk   = ext;
      cfg_clk_inv   = inv;
      cfg_reload_wr = 1'b1;
      @(negedge clk);
      cfg_reload_wr = 1'b0;
   endtask

   task automatic wait_tx(input int limit, output int cnt);
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!tx_tick && cnt < limit);
   endtask

   // Measures two tx tick intervals; in sync mode also checks clock level and rx tick midway.
   task automatic measure(input bit full, input int sel, input int n,
                          input bit uart, input bit inv, input string req);
      int exp, c;
      exp = exp_period(full, sel, n, uart);
      wait_tx(3 * exp + 50, c);
      chk(tx_tick === 1'b1, {req, " first tick"}, tx_tick, 1);
      for (int k = 0; k < 2; k++) begin
         if (uart) chk(rx_tick === 1'b1, "R4 rx with tx", rx_tick, 1);
         else      chk((sclk_out ^ inv) === 1'b1, "R5 level high at tx tick", sclk_out, 1 ^ inv);
         c = 0;
         do begin
            @(negedge clk);
            c++;
            if (!uart && c == 1)
               chk((sclk_out ^ inv) === 1'b0, "R5 level falls after tx tick", sclk_out, inv);
            if (!uart && c == exp / 2)
               chk(rx_tick === 1'b1, "R5 rx tick midway", rx_tick, 1);
         end while (!tx_tick && c < 2 * exp + 10);
         chk(c == exp, {req, " period"}, c, exp);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int c;
      logic [2:0] uart_codes [4];
      uart_codes[0] = 3'b010; uart_codes[1] = 3'b100;
      uart_codes[2] = 3'b101; uart_codes[3] = 3'b110;
      void'($urandom(32'h5EED_0017));

      repeat (3) @(negedge clk);
      // R12 reset state
      chk(tx_tick === 1'b0 && rx_tick === 1'b0, "R12 ticks idle", tx_tick, 0);
      chk(sclk_oe === 1'b0, "R12 clock pin released", sclk_oe, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9 first tick after reload write
      configure(1'b1, 0, 3, 3'b010, 1'b0, 1'b0);
      c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (!tx_tick && c < 200);
      chk(c == 64, "R9 first tick after restart", c, 64);

      // R1 R3 base rate and reload (directed)
      configure(1'b0, 0, 0, 3'b100, 1'b0, 1'b0);
      measure(1'b0, 0, 0, 1'b1, 1'b0, "R1 half base");
      configure(1'b1, 0, 5, 3'b101, 1'b0, 1'b0);
      measure(1'b1, 0, 5, 1'b1, 1'b0, "R3 reload 5");

      // R6 UART ignores external select
      configure(1'b1, 1, 0, 3'b110, 1'b1, 1'b0);
      chk(sclk_oe === 1'b0, "R6 no drive in UART", sclk_oe, 0);
      measure(1'b1, 1, 0, 1'b1, 1'b0, "R6 UART internal timing");

      // Random mix: R1 R2 R3 R4 R5 R7
      for (int t = 0; t < 10; t++) begin
         bit full, uart, inv;
         int sel, n;
         logic [2:0] mode;
         full = 1'($urandom % 2);
         sel  = int'($urandom % 3);
         n    = (sel == 2) ? int'($urandom % 2) : ((sel == 1) ? int'($urandom % 8) : int'($urandom % 64));
         uart = ($urandom % 5) != 0;
         mode = uart ? uart_codes[$urandom % 4] : 3'b001;
         inv  = 1'($urandom % 2);
         configure(full, sel, n, mode, 1'b0, inv);
         if (!uart) chk(sclk_oe === 1'b1, "R5 clock pin driven", sclk_oe, 1);
         measure(full, sel, n, uart, inv, uart ? "R2 R3 R4 random" : "R5 R7 random");
      end

      // R2 reserved source select stops ticks
      configure(1'b1, 3, 0, 3'b010, 1'b0, 1'b0);
      wait_tx(3000, c);
      chk(c == 3000 && tx_tick === 1'b0, "R2 select 11 silent", c, 3000);

      // R8 unused mode codes
      for (int m = 0; m < 3; m++) begin
         logic [2:0] code;
         code = (m == 0) ? 3'b000 : ((m == 1) ? 3'b011 : 3'b111);
         configure(1'b1, 0, 0, code, 1'b0, 1'b0);
         chk(sclk_oe === 1'b0, "R8 clock pin released", sclk_oe, 0);
         wait_tx(400, c);
         chk(c == 400, "R8 no ticks", c, 400);
      end

      // R6 external clock edges
      configure(1'b1, 0, 0, 3'b001, 1'b1, 1'b0);
      chk(sclk_oe === 1'b0, "R6 external not driven", sclk_oe, 0);
      repeat (4) @(negedge clk);
      sclk_in = 1'b1;
      @(negedge clk);
      chk(rx_tick === 1'b0, "R6 rise not before second edge", rx_tick, 0);
      @(negedge clk);
      chk(rx_tick === 1'b1 && tx_tick === 1'b0, "R6 rise gives rx tick", rx_tick, 1);
      @(negedge clk);
      chk(rx_tick === 1'b0, "R6 rx tick one cycle", rx_tick, 0);
      sclk_in = 1'b0;
      repeat (2) @(negedge clk);
      chk(tx_tick === 1'b1 && rx_tick === 1'b0, "R6 fall gives tx tick", tx_tick, 1);
      // R7 inverted external input: pin rise becomes a fall
      cfg_clk_inv = 1'b1;
      repeat (5) @(negedge clk);
      sclk_in = 1'b1;
      repeat (2) @(negedge clk);
      chk(tx_tick === 1'b1 && rx_tick === 1'b0, "R7 inverted pin rise gives tx tick", tx_tick, 1);

      // R10 handshake pin
      cfg_hs_off = 1'b1; cts_n_in = 1'b1;
      repeat (3) @(negedge clk);
      chk(cts_ok === 1'b1 && rts_oe === 1'b0, "R10 pin unused", cts_ok, 1);
      cfg_hs_off = 1'b0; cfg_hs_rts = 1'b0;
      repeat (3) @(negedge clk);
      chk(cts_ok === 1'b0, "R10 CTS high blocks", cts_ok, 0);
      cts_n_in = 1'b0;
      @(negedge clk);
      chk(cts_ok === 1'b0, "R10 CTS after one edge", cts_ok, 0);
      @(negedge clk);
      chk(cts_ok === 1'b1, "R10 CTS after two edges", cts_ok, 1);
      cts_n_in = 1'b1; cfg_hs_rts = 1'b1; rx_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk(rts_oe === 1'b1 && rts_n_out === 1'b0, "R10 RTS low when ready", rts_n_out, 0);
      chk(cts_ok === 1'b1, "R10 RTS mode allows send", cts_ok, 1);
      rx_ready = 1'b0;
      @(negedge clk);
      chk(rts_n_out === 1'b1, "R10 RTS high when busy", rts_n_out, 1);

      // R11 data inversion
      for (int v = 0; v < 16; v++) begin
         rxd_pin = v[0]; cfg_rx_inv = v[1]; txd_int = v[2]; cfg_tx_inv = v[3];
         @(negedge clk);
         chk(rxd_int === (v[0] ^ v[1]), "R11 rxd", rxd_int, v[0] ^ v[1]);
         chk(txd_pin === (v[2] ^ v[3]), "R11 txd", txd_pin, v[2] ^ v[3]);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule